// File: doc/BRIEF.md
# SDRAM Timing Parameter Converter

This block turns the timing bytes of two memory slots into the clock counts that a DDR SDRAM controller programs into its timing fields. For each parameter the two slots are reduced to one value. A byte of all ones marks an empty slot and reads as zero. The larger (slower) value wins. That value is then converted into memory clocks with a rounding-up division. The memory clock is half the supplied bus clock.

Some fields are derived from others:
- The row cycle count is the sum of the active-to-precharge count and the precharge count.
- A refresh-to-activate count of zero falls back to that sum plus one.
- The write-to-read turnaround depends on the memory clock alone.
- A refresh interval comes from a per-slot code and a small rate table.

The work is sequenced by a start/done handshake. One multiplier and one serial divider are shared across six conversion steps. Firmware or a boot sequencer holds the inputs steady, pulses `start`, and reads all outputs once `done` pulses.

Top module: `sdram_timing_conv`

## Requirements
- R1: For every parameter, an input byte of 0xFF is treated as 0, and the larger of the two slot values is used.
- R2: Active-to-precharge and refresh-to-activate bytes are in whole nanoseconds. Precharge, activate-to-command and activate-to-activate bytes are in quarter nanoseconds and are shifted right by 2 before conversion.
- R3: The memory clock is `bus_mhz` shifted right by 1. A count is ceil(ns × memory MHz / 1000), so any nonzero remainder adds one.
- R4: Results saturate to their field widths: `tras_clk` at 15, `trp_clk`/`trcd_clk`/`trrd_clk` at 7, and `trfc_clk` at 31.
- R5: `trc_clk` equals `tras_clk` + `trp_clk`, using the saturated values.
- R6: If the combined refresh-to-activate byte is 0, `trfc_clk` is `trc_clk` + 1.
- R7: `twtr_clk` is 2 when the memory clock is above 198 MHz, and 1 otherwise (198 gives 1, 199 gives 2).
- R8: A refresh code uses only its low nibble, clamped to 5. It indexes the rates {15,3,7,31,62,125} at indices 0..5. The smaller of the two slot rates is used. 0xFF is not cleared here and so reads as 125.
- R9: `ref_int` = floor(rate × memory MHz / 16).
- R10: `start` seen while idle raises `busy` on the next edge. `done` is a one-cycle pulse on the 115th edge after the accepting edge (1 + 6 × 19 for the default widths), and `busy` is low in that cycle.
- R11: A `start` pulse while `busy` is high is ignored. It does not change the results or the timing, and it does not cause a second `done`.
- R12: After reset, `busy`, `done` and all results are 0. Results change only in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| bus_mhz | input | 10 | Bus clock in MHz (memory clock is half) |
| ras_ns_a | input | 8 | Slot A active-to-precharge, ns |
| ras_ns_b | input | 8 | Slot B active-to-precharge, ns |
| rp_qns_a | input | 8 | Slot A precharge, quarter ns |
| rp_qns_b | input | 8 | Slot B precharge, quarter ns |
| rcd_qns_a | input | 8 | Slot A activate-to-command, quarter ns |
| rcd_qns_b | input | 8 | Slot B activate-to-command, quarter ns |
| rrd_qns_a | input | 8 | Slot A activate-to-activate, quarter ns |
| rrd_qns_b | input | 8 | Slot B activate-to-activate, quarter ns |
| rfc_ns_a | input | 8 | Slot A refresh-to-activate, ns |
| rfc_ns_b | input | 8 | Slot B refresh-to-activate, ns |
| refcode_a | input | 8 | Slot A refresh rate code |
| refcode_b | input | 8 | Slot B refresh rate code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse, results updated |
| tras_clk | output | 4 | Active-to-precharge clocks |
| trp_clk | output | 3 | Precharge clocks |
| trcd_clk | output | 3 | Activate-to-command clocks |
| trrd_clk | output | 3 | Activate-to-activate clocks |
| trc_clk | output | 5 | Row cycle clocks |
| trfc_clk | output | 5 | Refresh-to-activate clocks |
| twtr_clk | output | 2 | Write-to-read turnaround clocks |
| ref_int | output | 16 | Refresh interval count |

## Verification
A step counter that skips or repeats a stage would store a quotient in the wrong field. It would also move `done` off its fixed 115-cycle slot, so both the latency check and the field values expose it at the first conversion. A divider with a wrong remainder bit or quotient bit shows up as an off-by-one count in every field whose product is not an exact multiple of 1000 or 16. Such products are chosen deliberately in several cases. A phase machine that accepts `start` while busy would restart the sequence, which stretches the latency or produces a second `done` pulse within about one conversion time.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int BYTE_W     = 8;
  localparam int RATE_W     = 7;
  localparam int CODE_MAX   = 5;
  localparam int QNS_SHIFT  = 2;
  localparam logic [BYTE_W-1:0] EMPTY_BYTE = '1;

  typedef logic [BYTE_W-1:0] spd_byte_t;

  typedef enum logic [2:0] {
    STEP_RAS, STEP_RP, STEP_RCD, STEP_RRD, STEP_RFC, STEP_REF
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_ISSUE, PH_WAIT, PH_FINISH
  } phase_e;

  // An all-ones byte stands for an empty slot.
  function automatic spd_byte_t clean_byte(input spd_byte_t b);
    return (b == EMPTY_BYTE) ? '0 : b;
  endfunction

  // Slower (larger) of the two slots after cleaning.
  function automatic spd_byte_t worst_of(input spd_byte_t a, input spd_byte_t b);
    spd_byte_t ca;
    spd_byte_t cb;
    ca = clean_byte(a);
    cb = clean_byte(b);
    return (ca > cb) ? ca : cb;
  endfunction

  // Low nibble, clamped, mapped to a refresh rate.
  function automatic logic [RATE_W-1:0] refresh_rate(input spd_byte_t code);
    logic [3:0] n;
    n = code[3:0];
    if (n > 4'(CODE_MAX)) n = 4'(CODE_MAX);
    case (n)
      4'd0:    return 7'd15;
      4'd1:    return 7'd3;
      4'd2:    return 7'd7;
      4'd3:    return 7'd31;
      4'd4:    return 7'd62;
      default: return 7'd125;
    endcase
  endfunction

  function automatic logic [31:0] sat_width(input logic [31:0] v, input int w);
    logic [31:0] lim;
    lim = (32'd1 << w) - 32'd1;
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [31:0] ceil_adjust(input logic [31:0] q, input logic rem_nz);
    return q + {31'd0, rem_nz};
  endfunction
endpackage

// File: rtl/sdt_operand_sel.sv
module sdt_operand_sel
  import sdt_pkg::*;
(
  input  step_e     step,
  input  spd_byte_t ras_a,
  input  spd_byte_t ras_b,
  input  spd_byte_t rp_a,
  input  spd_byte_t rp_b,
  input  spd_byte_t rcd_a,
  input  spd_byte_t rcd_b,
  input  spd_byte_t rrd_a,
  input  spd_byte_t rrd_b,
  input  spd_byte_t rfc_a,
  input  spd_byte_t rfc_b,
  input  spd_byte_t ref_a,
  input  spd_byte_t ref_b,
  output spd_byte_t operand,
  output logic      rfc_absent
);
  spd_byte_t         w_ras, w_rp, w_rcd, w_rrd, w_rfc;
  logic [RATE_W-1:0] rate_a, rate_b, rate_min;

  always_comb begin
    w_ras    = worst_of(ras_a, ras_b);
    w_rp     = worst_of(rp_a, rp_b);
    w_rcd    = worst_of(rcd_a, rcd_b);
    w_rrd    = worst_of(rrd_a, rrd_b);
    w_rfc    = worst_of(rfc_a, rfc_b);
    rate_a   = refresh_rate(ref_a);
    rate_b   = refresh_rate(ref_b);
    rate_min = (rate_a < rate_b) ? rate_a : rate_b;
    unique case (step)
      STEP_RAS: operand = w_ras;
      STEP_RP:  operand = w_rp  >> QNS_SHIFT;
      STEP_RCD: operand = w_rcd >> QNS_SHIFT;
      STEP_RRD: operand = w_rrd >> QNS_SHIFT;
      STEP_RFC: operand = w_rfc;
      default:  operand = BYTE_W'(rate_min);
    endcase
    rfc_absent = (w_rfc == '0);
  end
endmodule

// File: rtl/sdt_serial_div.sv
module sdt_serial_div #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             fin,
  output logic [NUM_W-1:0] quotient,
  output logic             rem_nz
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc;
  logic [DEN_W-1:0] rem, den_q;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DEN_W:0]   trial;
  logic             fits;

  always_comb begin
    trial = {rem, acc[NUM_W-1]};
    fits  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc   <= dividend;
        rem   <= '0;
        den_q <= divisor;
        cnt   <= CNT_W'(NUM_W);
        run   <= 1'b1;
      end else if (run) begin
        acc <= {acc[NUM_W-2:0], fits};
        rem <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quotient = acc;
  assign rem_nz   = |rem;
endmodule

// File: rtl/sdt_derive.sv
module sdt_derive
  import sdt_pkg::*;
#(
  parameter int RAS_W    = 4,
  parameter int SHORT_W  = 3,
  parameter int RFC_W    = 5,
  parameter int TRC_W    = 5,
  parameter int MEM_W    = 9,
  parameter int TWTR_MHZ = 198
) (
  input  logic [RAS_W-1:0]   ras_f,
  input  logic [SHORT_W-1:0] rp_f,
  input  logic [RFC_W-1:0]   rfc_f,
  input  logic               rfc_absent,
  input  logic [MEM_W-1:0]   mem_mhz,
  output logic [TRC_W-1:0]   trc,
  output logic [RFC_W-1:0]   trfc,
  output logic [1:0]         twtr
);
  always_comb begin
    trc  = TRC_W'(ras_f) + TRC_W'(rp_f);
    trfc = rfc_absent ? RFC_W'(sat_width(32'(trc) + 32'd1, RFC_W)) : rfc_f;
    twtr = (32'(mem_mhz) > 32'(TWTR_MHZ)) ? 2'd2 : 2'd1;
  end
endmodule

// File: rtl/sdram_timing_conv.sv
module sdram_timing_conv
  import sdt_pkg::*;
#(
  parameter int BUS_W    = 10,
  parameter int RAS_W    = 4,
  parameter int SHORT_W  = 3,
  parameter int RFC_W    = 5,
  parameter int REF_W    = 16,
  parameter int NS_DIV   = 1000,
  parameter int REF_DIV  = 16,
  parameter int TWTR_MHZ = 198
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BUS_W-1:0]   bus_mhz,
  input  logic [7:0]         ras_ns_a,
  input  logic [7:0]         ras_ns_b,
  input  logic [7:0]         rp_qns_a,
  input  logic [7:0]         rp_qns_b,
  input  logic [7:0]         rcd_qns_a,
  input  logic [7:0]         rcd_qns_b,
  input  logic [7:0]         rrd_qns_a,
  input  logic [7:0]         rrd_qns_b,
  input  logic [7:0]         rfc_ns_a,
  input  logic [7:0]         rfc_ns_b,
  input  logic [7:0]         refcode_a,
  input  logic [7:0]         refcode_b,
  output logic               busy,
  output logic               done,
  output logic [RAS_W-1:0]   tras_clk,
  output logic [SHORT_W-1:0] trp_clk,
  output logic [SHORT_W-1:0] trcd_clk,
  output logic [SHORT_W-1:0] trrd_clk,
  output logic [RAS_W:0]     trc_clk,
  output logic [RFC_W-1:0]   trfc_clk,
  output logic [1:0]         twtr_clk,
  output logic [REF_W-1:0]   ref_int
);
  localparam int MEM_W  = BUS_W - 1;
  localparam int PROD_W = BYTE_W + MEM_W;
  localparam int TRC_W  = RAS_W + 1;
  localparam int DEN_W  = $clog2(NS_DIV + 1);

  phase_e              phase;
  step_e               step;
  logic [MEM_W-1:0]    mem_mhz;
  spd_byte_t           operand;
  logic                rfc_absent;
  logic                div_go, div_fin, div_rem_nz;
  logic [PROD_W-1:0]   dividend, quotient;
  logic [DEN_W-1:0]    divisor;
  logic [31:0]         q_floor, q_ceil;
  logic [RAS_W-1:0]    ras_f;
  logic [SHORT_W-1:0]  rp_f, rcd_f, rrd_f;
  logic [RFC_W-1:0]    rfc_f;
  logic [REF_W-1:0]    ref_f;
  logic [TRC_W-1:0]    trc_d;
  logic [RFC_W-1:0]    trfc_d;
  logic [1:0]          twtr_d;

  assign mem_mhz  = bus_mhz[BUS_W-1:1];
  assign div_go   = (phase == PH_ISSUE);
  assign dividend = PROD_W'(operand) * PROD_W'(mem_mhz);
  assign divisor  = (step == STEP_REF) ? DEN_W'(REF_DIV) : DEN_W'(NS_DIV);
  assign q_floor  = 32'(quotient);
  assign q_ceil   = ceil_adjust(q_floor, div_rem_nz);
  assign busy     = (phase != PH_IDLE);

  sdt_operand_sel u_sel (
    .step      (step),
    .ras_a     (ras_ns_a),  .ras_b (ras_ns_b),
    .rp_a      (rp_qns_a),  .rp_b  (rp_qns_b),
    .rcd_a     (rcd_qns_a), .rcd_b (rcd_qns_b),
    .rrd_a     (rrd_qns_a), .rrd_b (rrd_qns_b),
    .rfc_a     (rfc_ns_a),  .rfc_b (rfc_ns_b),
    .ref_a     (refcode_a), .ref_b (refcode_b),
    .operand   (operand),
    .rfc_absent(rfc_absent)
  );

  sdt_serial_div #(.NUM_W(PROD_W), .DEN_W(DEN_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (div_go),
    .dividend(dividend),
    .divisor (divisor),
    .fin     (div_fin),
    .quotient(quotient),
    .rem_nz  (div_rem_nz)
  );

  sdt_derive #(
    .RAS_W(RAS_W), .SHORT_W(SHORT_W), .RFC_W(RFC_W), .TRC_W(TRC_W),
    .MEM_W(MEM_W), .TWTR_MHZ(TWTR_MHZ)
  ) u_derive (
    .ras_f     (ras_f),
    .rp_f      (rp_f),
    .rfc_f     (rfc_f),
    .rfc_absent(rfc_absent),
    .mem_mhz   (mem_mhz),
    .trc       (trc_d),
    .trfc      (trfc_d),
    .twtr      (twtr_d)
  );

  // Sequencer: one divide per step, results parked until the finish cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= STEP_RAS;
      ras_f <= '0;
      rp_f  <= '0;
      rcd_f <= '0;
      rrd_f <= '0;
      rfc_f <= '0;
      ref_f <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          step  <= STEP_RAS;
          phase <= PH_ISSUE;
        end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT: if (div_fin) begin
          unique case (step)
            STEP_RAS: ras_f <= RAS_W'(sat_width(q_ceil, RAS_W));
            STEP_RP:  rp_f  <= SHORT_W'(sat_width(q_ceil, SHORT_W));
            STEP_RCD: rcd_f <= SHORT_W'(sat_width(q_ceil, SHORT_W));
            STEP_RRD: rrd_f <= SHORT_W'(sat_width(q_ceil, SHORT_W));
            STEP_RFC: rfc_f <= RFC_W'(sat_width(q_ceil, RFC_W));
            default:  ref_f <= REF_W'(sat_width(q_floor, REF_W));
          endcase
          if (step == STEP_REF) begin
            phase <= PH_FINISH;
          end else begin
            step  <= step_e'(step + 3'd1);
            phase <= PH_ISSUE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Output bank: loaded once per conversion, together with done.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      tras_clk <= '0;
      trp_clk  <= '0;
      trcd_clk <= '0;
      trrd_clk <= '0;
      trc_clk  <= '0;
      trfc_clk <= '0;
      twtr_clk <= '0;
      ref_int  <= '0;
    end else begin
      done <= (phase == PH_FINISH);
      if (phase == PH_FINISH) begin
        tras_clk <= ras_f;
        trp_clk  <= rp_f;
        trcd_clk <= rcd_f;
        trrd_clk <= rrd_f;
        trc_clk  <= trc_d;
        trfc_clk <= trfc_d;
        twtr_clk <= twtr_d;
        ref_int  <= ref_f;
      end
    end
  end
endmodule

// File: rtl/sdt_checker.sv
module sdt_checker #(
  parameter int RAS_W   = 4,
  parameter int SHORT_W = 3,
  parameter int RFC_W   = 5,
  parameter int REF_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               div_fin,
  input logic [RAS_W-1:0]   tras_clk,
  input logic [SHORT_W-1:0] trp_clk,
  input logic [RAS_W:0]     trc_clk,
  input logic [RFC_W-1:0]   trfc_clk,
  input logic [1:0]         twtr_clk,
  input logic [REF_W-1:0]   ref_int
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_fin_inside_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> busy);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(tras_clk) && $stable(trp_clk) && $stable(trc_clk) &&
               $stable(trfc_clk) && $stable(twtr_clk) && $stable(ref_int)));

  assert_trc_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trc_clk == ((RAS_W+1)'(tras_clk) + (RAS_W+1)'(trp_clk))));

  assert_trfc_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trfc_clk != '0));

  assert_twtr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (twtr_clk == 2'd1 || twtr_clk == 2'd2));
endmodule

bind sdram_timing_conv sdt_checker #(
  .RAS_W(RAS_W), .SHORT_W(SHORT_W), .RFC_W(RFC_W), .REF_W(REF_W)
) u_sdt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .div_fin (div_fin),
  .tras_clk(tras_clk),
  .trp_clk (trp_clk),
  .trc_clk (trc_clk),
  .trfc_clk(trfc_clk),
  .twtr_clk(twtr_clk),
  .ref_int (ref_int)
);

// File: tb/test_sdram_timing_conv.sv
module test_sdram_timing_conv;
  localparam int LAT = 1 + 6 * (8 + 9 + 2);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] bus_mhz = '0;
  logic [7:0] ras_a = 0, ras_b = 0, rp_a = 0, rp_b = 0, rcd_a = 0, rcd_b = 0;
  logic [7:0] rrd_a = 0, rrd_b = 0, rfc_a = 0, rfc_b = 0, rc_a = 0, rc_b = 0;
  logic       busy, done;
  logic [3:0] tras_clk;
  logic [2:0] trp_clk, trcd_clk, trrd_clk;
  logic [4:0] trc_clk, trfc_clk;
  logic [1:0] twtr_clk;
  logic [15:0] ref_int;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sdram_timing_conv i_sdram_timing_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
    .ras_ns_a(ras_a), .ras_ns_b(ras_b), .rp_qns_a(rp_a), .rp_qns_b(rp_b),
    .rcd_qns_a(rcd_a), .rcd_qns_b(rcd_b), .rrd_qns_a(rrd_a), .rrd_qns_b(rrd_b),
    .rfc_ns_a(rfc_a), .rfc_ns_b(rfc_b), .refcode_a(rc_a), .refcode_b(rc_b),
    .busy(busy), .done(done), .tras_clk(tras_clk), .trp_clk(trp_clk),
    .trcd_clk(trcd_clk), .trrd_clk(trrd_clk), .trc_clk(trc_clk),
    .trfc_clk(trfc_clk), .twtr_clk(twtr_clk), .ref_int(ref_int)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Independent reference model, written with plain integers.
  function automatic int cl(input int b); return (b == 255) ? 0 : b; endfunction
  function automatic int mx(input int a, input int b);
    return (cl(a) > cl(b)) ? cl(a) : cl(b);
  endfunction
  function automatic int to_clk(input int ns, input int lim);
    int v;
    v = (ns * (bus_mhz / 2) + 999) / 1000;
    return (v > lim) ? lim : v;
  endfunction
  function automatic int rate_of(input int code);
    int n;
    n = code % 16;
    if (n > 5) n = 5;
    case (n)
      0: return 15;
      1: return 3;
      2: return 7;
      3: return 31;
      4: return 62;
      default: return 125;
    endcase
  endfunction

  task automatic set_in(input int bus, input int a0, input int a1, input int p0, input int p1,
                        input int c0, input int c1, input int r0, input int r1,
                        input int f0, input int f1, input int k0, input int k1);
    bus_mhz = 10'(bus);
    ras_a = 8'(a0); ras_b = 8'(a1); rp_a = 8'(p0); rp_b = 8'(p1);
    rcd_a = 8'(c0); rcd_b = 8'(c1); rrd_a = 8'(r0); rrd_b = 8'(r1);
    rfc_a = 8'(f0); rfc_b = 8'(f1); rc_a = 8'(k0); rc_b = 8'(k1);
  endtask

  // Starts a run; optionally pokes start again at a given cycle.
  task automatic launch(input int poke_at, output int lat);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; lat = 0;
    while (!done && lat < 1000) begin
      if (lat == poke_at) start = 1'b1;
      else start = 1'b0;
      @(negedge clk); lat++;
    end
    start = 1'b0;
  endtask

  task automatic compare_model(input string tag);
    int e_ras, e_rp, e_rcd, e_rrd, e_trc, e_rfc, e_twtr, e_ref, wr, mem, k0, k1;
    mem   = bus_mhz / 2;
    e_ras = to_clk(mx(ras_a, ras_b), 15);
    e_rp  = to_clk(mx(rp_a, rp_b) / 4, 7);
    e_rcd = to_clk(mx(rcd_a, rcd_b) / 4, 7);
    e_rrd = to_clk(mx(rrd_a, rrd_b) / 4, 7);
    e_trc = e_ras + e_rp;
    wr    = mx(rfc_a, rfc_b);
    e_rfc = (wr == 0) ? e_trc + 1 : to_clk(wr, 31);
    e_twtr = (mem > 198) ? 2 : 1;
    k0 = rate_of(rc_a); k1 = rate_of(rc_b);
    e_ref = ((k0 < k1) ? k0 : k1) * mem / 16;
    chk({tag, " R1 R3 tras"}, tras_clk, e_ras);
    chk({tag, " R2 R3 trp"}, trp_clk, e_rp);
    chk({tag, " R2 R3 trcd"}, trcd_clk, e_rcd);
    chk({tag, " R2 R3 trrd"}, trrd_clk, e_rrd);
    chk({tag, " R5 trc"}, trc_clk, e_trc);
    chk({tag, " R6 trfc"}, trfc_clk, e_rfc);
    chk({tag, " R7 twtr"}, twtr_clk, e_twtr);
    chk({tag, " R8 R9 ref"}, ref_int, e_ref);
  endtask

  task automatic t_reset;
    chk("R12 busy at reset", busy, 0);
    chk("R12 done at reset", done, 0);
    chk("R12 tras at reset", tras_clk, 0);
    chk("R12 ref at reset", ref_int, 0);
  endtask

  task automatic t_typical;
    int lat;
    set_in(400, 45, 40, 60, 255, 60, 72, 40, 48, 75, 0, 8'h82, 8'h80);
    launch(-1, lat);
    chk("R10 latency", lat, LAT);
    chk("R10 busy low at done", busy, 0);
    chk("R1 tras hand", tras_clk, 9);
    chk("R2 trp hand", trp_clk, 3);
    chk("R3 trcd ceil hand", trcd_clk, 4);
    chk("R3 trrd ceil hand", trrd_clk, 3);
    chk("R5 trc hand", trc_clk, 12);
    chk("R6 trfc hand", trfc_clk, 15);
    chk("R7 twtr hand", twtr_clk, 2);
    chk("R9 ref floor hand", ref_int, 87);
    compare_model("typical");
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  task automatic t_empty_slot;
    int lat;
    set_in(266, 42, 255, 72, 255, 80, 255, 60, 255, 255, 255, 8'h01, 8'hFF);
    launch(-1, lat);
    chk("R6 fallback trfc hand", trfc_clk, 10);
    chk("R8 ref empty code hand", ref_int, 24);
    compare_model("empty slot");
  endtask

  task automatic t_saturate;
    int lat;
    set_in(1023, 250, 10, 240, 8, 254, 3, 4, 4, 250, 9, 8'h0A, 8'hFF);
    launch(-1, lat);
    chk("R4 tras sat", tras_clk, 15);
    chk("R4 trp sat", trp_clk, 7);
    chk("R4 trfc sat", trfc_clk, 31);
    chk("R8 clamp ref", ref_int, 3992);
    compare_model("saturate");
  endtask

  task automatic t_twtr_edge;
    int lat;
    set_in(397, 30, 50, 12, 20, 40, 36, 28, 32, 0, 70, 8'h33, 8'h34);
    launch(-1, lat);
    chk("R7 twtr at 198", twtr_clk, 1);
    compare_model("mem198");
    bus_mhz = 10'd398;
    launch(-1, lat);
    chk("R7 twtr at 199", twtr_clk, 2);
    compare_model("mem199");
  endtask

  task automatic t_zero;
    int lat;
    set_in(200, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h05, 8'h04);
    launch(-1, lat);
    chk("R6 zero fallback", trfc_clk, 1);
    compare_model("zero");
  endtask

  task automatic t_ignore_start;
    int lat, extra;
    set_in(333, 37, 44, 55, 57, 61, 59, 43, 45, 105, 110, 8'h02, 8'h03);
    launch(30, lat);
    chk("R11 latency with poke", lat, LAT);
    compare_model("poke");
    extra = 0;
    for (int i = 0; i < LAT + 20; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R11 no second done", extra, 0);
    chk("R11 idle after", busy, 0);
    compare_model("poke held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_typical();
    t_empty_slot();
    t_saturate();
    t_twtr_edge();
    t_zero();
    t_ignore_start();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule